// File: doc/BRIEF.md
# Ternary Operand Fetch Unit

This sequential unit resolves the second operand of a ternary instruction. On a start pulse it captures a 2-trit mode field, a 2-trit selector field and a flag that marks the instruction as unary or nullary. It reads the selected register and, depending on the mode, also does the following:

- takes the word that follows in the code stream;
- adjusts a pointer register by one;
- reads the 2187-word data memory.

When the operand is ready it raises `done` for one cycle. With `done` it returns the operand, the effective memory address, and whether an extra code word was consumed.

The unit sits between the decode stage and the execute stage. The register file, the data memory and the code stream stay outside. The register file is read combinationally and written on the clock edge that ends the cycle in which `rf_we` is high. The data memory is synchronous: it returns the word one cycle after `mem_re`. The code word must be valid while `code_take` is high.

Top module: `tern_opfetch`

## Requirements
- R1: A trit is two bits: 00 is zero, 01 is +1 and 10 is −1. A word is 9 trits, with trit 0 in bits [1:0] as the least significant trit. A 2-trit field has the value 3·t1 + t0, where t0 is bits [1:0]. The selector value plus 4 gives the register index: 0–5 are the general registers, 6 is the flag register, 7 is the stack pointer and 8 is the program counter.
- R2: The mode value selects the addressing mode as follows:
  - −4: register
  - −3: next word
  - −2: immediate
  - −1: indirect
  - 0: pre-increment
  - +1: post-increment
  - +2: pre-decrement
  - +3: post-decrement
  - +4: offset
- R3: In register mode the operand is the selected register. In immediate mode the operand is the selector field padded with zero trits. In both modes there is no memory read, no register write and an effective address of zero, and `done` rises two clock edges after the start edge.
- R4: In next-word mode the operand is `code_word`, `code_take` is high for exactly one cycle, and `extra_word` is 1.
- R5: In indirect mode the unit reads memory once at the low 7 trits of the selected register. The operand is the returned word, and `done` rises four clock edges after the start edge.
- R6: Pre-increment and pre-decrement write the register ±1 back. Memory is then read at the new value.
- R7: Post-increment and post-decrement read memory at the old register value. The register is written back ±1.
- R8: Offset mode reads memory at the register plus `code_word`. It takes one code word, reports `extra_word` = 1, and leaves the register unchanged.
- R9: Word arithmetic wraps modulo 3^9 (9841 + 1 becomes −9841). The effective address is the low 7 trits of the computed value, with the upper trits dropped.
- R10: With `unary` set, the operand, effective address and `extra_word` are zero. There is no memory read, no register write and no code take, and `done` rises two edges after start.
- R11: `done` lasts one cycle. A start that arrives while an operand is being resolved is ignored.
- R12: After reset, `done`, `rf_we`, `mem_re`, `code_take`, `extra_word`, `operand` and `eff_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving an operand (accepted when idle) |
| unary | input | 1 | Instruction takes no operand; suppress all lookups |
| mode_fld | input | 4 | 2-trit addressing mode |
| sel_fld | input | 4 | 2-trit register selector / immediate |
| rf_idx | output | 4 | Register index for read and write-back |
| rf_rdata | input | 18 | Register contents at `rf_idx` |
| rf_we | output | 1 | Write `rf_wdata` to register `rf_idx` |
| rf_wdata | output | 18 | Adjusted pointer value |
| mem_re | output | 1 | Data memory read strobe |
| mem_addr | output | 14 | 7-trit data memory address |
| mem_rdata | input | 18 | Data word, valid the cycle after `mem_re` |
| code_word | input | 18 | Word following the instruction in the code stream |
| code_take | output | 1 | `code_word` is consumed this cycle |
| done | output | 1 | Operand ready (one cycle) |
| operand | output | 18 | Resolved operand |
| eff_addr | output | 14 | Effective memory address (zero for non-memory modes) |
| extra_word | output | 1 | A code word was consumed |

## Verification
The cases hardest to reach are the ones where carries run through every trit of the pointer adder. The bench seeds the selected register with 9841 under pre-increment to cover wrap-around. It also uses offsets whose sum leaves the 7-trit address range, so that truncation to the low 7 trits is visible on `eff_addr` and on the data returned. A second start pulse is placed while a memory mode is still in flight, and the bench counts `done` pulses over the following window. Unary instructions are issued with pointer and offset modes, so that any stray write, read or code take shows up in the pulse counters.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FETCH,
        ST_DATA
    } fetch_state_e;

    typedef enum logic [3:0] {
        AM_REG     = 4'd0,
        AM_NEXT    = 4'd1,
        AM_IMM     = 4'd2,
        AM_IND     = 4'd3,
        AM_PREINC  = 4'd4,
        AM_POSTINC = 4'd5,
        AM_PREDEC  = 4'd6,
        AM_POSTDEC = 4'd7,
        AM_OFFSET  = 4'd8
    } amode_e;

    // Value of one trit; the unused code 11 reads as zero.
    function automatic int tval(logic [1:0] t);
        case (t)
            2'b01:   return 1;
            2'b10:   return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] tenc(int v);
        if (v > 0)      return 2'b01;
        else if (v < 0) return 2'b10;
        else            return 2'b00;
    endfunction

    function automatic logic [1:0] tsum(logic [1:0] a, logic [1:0] b, logic [1:0] c);
        int s;
        s = tval(a) + tval(b) + tval(c);
        if (s > 1)       s = s - 3;
        else if (s < -1) s = s + 3;
        return tenc(s);
    endfunction

    function automatic logic [1:0] tcarry(logic [1:0] a, logic [1:0] b, logic [1:0] c);
        int s;
        s = tval(a) + tval(b) + tval(c);
        if (s > 1)       return 2'b01;
        else if (s < -1) return 2'b10;
        else             return 2'b00;
    endfunction

endpackage

// File: rtl/tern_field_dec.sv
module tern_field_dec #(
    parameter int IW = 4
) (
    input  logic [3:0]    fld,
    output logic [IW-1:0] idx
);
    import tern_pkg::*;

    always_comb begin
        idx = IW'(3 * tval(fld[3:2]) + tval(fld[1:0]) + 4);
    end

endmodule

// File: rtl/tern_add.sv
module tern_add #(
    parameter int TRITS = 9,
    localparam int W = 2 * TRITS
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    import tern_pkg::*;

    logic [1:0] cy [TRITS];

    assign cy[0] = 2'b00;

    for (genvar i = 0; i < TRITS; i++) begin : g_trit
        assign sum[2*i +: 2] = tsum(a[2*i +: 2], b[2*i +: 2], cy[i]);
        if (i < TRITS - 1) begin : g_cy
            assign cy[i+1] = tcarry(a[2*i +: 2], b[2*i +: 2], cy[i]);
        end
    end

endmodule

// File: rtl/tern_opfetch.sv
module tern_opfetch #(
    parameter int TRITS  = 9,
    parameter int ATRITS = 7,
    parameter int NREG   = 9,
    localparam int W  = 2 * TRITS,
    localparam int AW = 2 * ATRITS,
    localparam int RW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          unary,
    input  logic [3:0]    mode_fld,
    input  logic [3:0]    sel_fld,
    output logic [RW-1:0] rf_idx,
    input  logic [W-1:0]  rf_rdata,
    output logic          rf_we,
    output logic [W-1:0]  rf_wdata,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    input  logic [W-1:0]  mem_rdata,
    input  logic [W-1:0]  code_word,
    output logic          code_take,
    output logic          done,
    output logic [W-1:0]  operand,
    output logic [AW-1:0] eff_addr,
    output logic          extra_word
);
    import tern_pkg::*;

    localparam logic [W-1:0] PLUS_ONE  = W'(2'b01);
    localparam logic [W-1:0] MINUS_ONE = W'(2'b10);

    typedef struct packed {
        fetch_state_e  st;
        logic          unary;
        logic [3:0]    mode;
        logic [3:0]    sel;
        logic [AW-1:0] addr;
        logic [W-1:0]  operand;
        logic [AW-1:0] eff;
        logic          extra;
        logic          done;
    } fetch_regs_t;

    fetch_regs_t q, d;

    logic [3:0]   mode_idx;
    amode_e       mode_e;
    logic [W-1:0] addend;
    logic [W-1:0] sum_w;
    logic [3:0]   imm_fld;

    tern_field_dec #(.IW(4)) u_mode_dec (
        .fld (q.mode),
        .idx (mode_idx)
    );

    tern_field_dec #(.IW(RW)) u_sel_dec (
        .fld (q.sel),
        .idx (rf_idx)
    );

    tern_add #(.TRITS(TRITS)) u_ptr_add (
        .a   (rf_rdata),
        .b   (addend),
        .sum (sum_w)
    );

    assign mode_e  = amode_e'(mode_idx);
    assign imm_fld = {tenc(tval(q.sel[3:2])), tenc(tval(q.sel[1:0]))};

    always_comb begin
        case (mode_e)
            AM_PREINC, AM_POSTINC: addend = PLUS_ONE;
            AM_PREDEC, AM_POSTDEC: addend = MINUS_ONE;
            AM_OFFSET:             addend = code_word;
            default:               addend = '0;
        endcase
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        rf_we     = 1'b0;
        code_take = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_LOOK;
                    d.unary = unary;
                    d.mode  = mode_fld;
                    d.sel   = sel_fld;
                end
            end
            ST_LOOK: begin
                d.extra = 1'b0;
                d.eff   = '0;
                d.st    = ST_IDLE;
                if (q.unary) begin
                    d.operand = '0;
                    d.done    = 1'b1;
                end else begin
                    case (mode_e)
                        AM_REG: begin
                            d.operand = rf_rdata;
                            d.done    = 1'b1;
                        end
                        AM_NEXT: begin
                            d.operand = code_word;
                            d.extra   = 1'b1;
                            code_take = 1'b1;
                            d.done    = 1'b1;
                        end
                        AM_IMM: begin
                            d.operand = W'(imm_fld);
                            d.done    = 1'b1;
                        end
                        AM_IND: begin
                            d.addr = rf_rdata[AW-1:0];
                            d.st   = ST_FETCH;
                        end
                        AM_PREINC, AM_PREDEC: begin
                            d.addr = sum_w[AW-1:0];
                            rf_we  = 1'b1;
                            d.st   = ST_FETCH;
                        end
                        AM_POSTINC, AM_POSTDEC: begin
                            d.addr = rf_rdata[AW-1:0];
                            rf_we  = 1'b1;
                            d.st   = ST_FETCH;
                        end
                        AM_OFFSET: begin
                            d.addr    = sum_w[AW-1:0];
                            code_take = 1'b1;
                            d.extra   = 1'b1;
                            d.st      = ST_FETCH;
                        end
                        default: begin
                            d.operand = '0;
                            d.done    = 1'b1;
                        end
                    endcase
                end
            end
            ST_FETCH: d.st = ST_DATA;
            ST_DATA: begin
                d.operand = mem_rdata;
                d.eff     = q.addr;
                d.done    = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rf_wdata   = sum_w;
    assign mem_re     = (q.st == ST_FETCH);
    assign mem_addr   = q.addr;
    assign done       = q.done;
    assign operand    = q.operand;
    assign eff_addr   = q.eff;
    assign extra_word = q.extra;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    read_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ##1 done);

    // R6 R7
    writeback_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata != rf_rdata));

    // R10
    unary_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOOK && q.unary) |=> !mem_re && done && !extra_word);

    // R4 R8
    take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_take |=> !code_take);

endmodule

// File: tb/tb_tern_opfetch.sv
`timescale 1ns/1ps
module tb_tern_opfetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        unary = 1'b0;
    logic [3:0]  mode_fld = '0;
    logic [3:0]  sel_fld = '0;
    logic [3:0]  rf_idx;
    logic [17:0] rf_rdata;
    logic        rf_we;
    logic [17:0] rf_wdata;
    logic        mem_re;
    logic [13:0] mem_addr;
    logic [17:0] mem_rdata = '0;
    logic [17:0] code_word = '0;
    logic        code_take;
    logic        done;
    logic [17:0] operand;
    logic [13:0] eff_addr;
    logic        extra_word;

    always #5 clk = ~clk;

    tern_opfetch dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unary(unary),
        .mode_fld(mode_fld), .sel_fld(sel_fld),
        .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .code_word(code_word), .code_take(code_take),
        .done(done), .operand(operand), .eff_addr(eff_addr), .extra_word(extra_word)
    );

    int checks = 0;
    int fails  = 0;
    int n_mem = 0, n_we = 0, n_take = 0, n_done = 0;

    function automatic logic [17:0] to_word(int v);
        logic [17:0] w;
        int m;
        w = '0;
        for (int i = 0; i < 9; i++) begin
            m = v % 3;
            if (m > 1)  m = m - 3;
            if (m < -1) m = m + 3;
            w[2*i +: 2] = (m > 0) ? 2'b01 : (m < 0) ? 2'b10 : 2'b00;
            v = (v - m) / 3;
        end
        return w;
    endfunction

    function automatic int from_word(logic [17:0] w);
        int v, p;
        v = 0; p = 1;
        for (int i = 0; i < 9; i++) begin
            if (w[2*i +: 2] == 2'b01) v = v + p;
            else if (w[2*i +: 2] == 2'b10) v = v - p;
            p = p * 3;
        end
        return v;
    endfunction

    // Register file and memory models (memory word = address*5+1)
    logic [17:0] regs [9];
    assign rf_rdata = regs[rf_idx];

    always @(posedge clk) begin
        if (rf_we) regs[rf_idx] <= rf_wdata;
        mem_rdata <= to_word(from_word({4'b0, mem_addr}) * 5 + 1);
        if (mem_re)    n_mem  <= n_mem + 1;
        if (rf_we)     n_we   <= n_we + 1;
        if (code_take) n_take <= n_take + 1;
        if (done)      n_done <= n_done + 1;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode, sel, unary, regval, code, exp_op, exp_eff, exp_extra, exp_reg, exp_mem
    localparam int NV = 15;
    localparam int VEC [NV][10] = '{
        '{-4, -4, 0,   123,    0,   123,     0, 0,   123, 0},
        '{-4,  4, 0,   -77,    0,   -77,     0, 0,   -77, 0},
        '{-3,  0, 0,     5, 4321,  4321,     0, 1,     5, 0},
        '{-2, -4, 0,     7,    0,    -4,     0, 0,     7, 0},
        '{-2,  3, 0,     7,    0,     3,     0, 0,     7, 0},
        '{-1,  1, 0,    10,    0,    51,    10, 0,    10, 1},
        '{ 0,  3, 0,   100,    0,   506,   101, 0,   101, 1},
        '{ 1, -1, 0,   -20,    0,   -99,   -20, 0,   -19, 1},
        '{ 2,  2, 0,     0,    0,    -4,    -1, 0,    -1, 1},
        '{ 3, -2, 0,  1093,    0,  5466,  1093, 0,  1092, 1},
        '{ 4, -3, 0,  1000,  200, -4934,  -987, 1,  1000, 1},
        '{ 0, -4, 0,  9841,    0, -5464, -1093, 0, -9841, 1},
        '{ 4, -3, 0,  -500, -700,  4936,   987, 1,  -500, 1},
        '{ 1,  0, 1,    55,   77,     0,     0, 0,    55, 0},
        '{ 4,  2, 1,    33,   88,     0,     0, 0,    33, 0}
    };
    localparam string TAG [NV] = '{
        "R1 R3", "R3", "R4", "R1 R3", "R3", "R5", "R2 R6", "R7",
        "R6", "R7", "R8 R9", "R6 R9", "R8 R9", "R10", "R10 R2"
    };

    task automatic run_op(int mode, int sel, int un, int code, output int lat);
        @(negedge clk);
        mode_fld  = to_word(mode) >> 0;
        sel_fld   = to_word(sel) >> 0;
        unary     = un[0];
        code_word = to_word(code);
        n_mem = 0; n_we = 0; n_take = 0; n_done = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < 9; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "done", int'(done), 0);
        chk("R12", "rf_we", int'(rf_we), 0);
        chk("R12", "mem_re", int'(mem_re), 0);
        chk("R12", "code_take", int'(code_take), 0);
        chk("R12", "operand", from_word(operand), 0);
        chk("R12", "extra_word", int'(extra_word), 0);

        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < 9; r++) regs[r] = '0;
            regs[VEC[v][1] + 4] = to_word(VEC[v][3]);
            run_op(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][4], lat);
            chk(TAG[v], "operand", from_word(operand), VEC[v][5]);
            chk(TAG[v], "eff_addr", from_word({4'b0, eff_addr}), VEC[v][6]);
            chk(TAG[v], "extra_word", int'(extra_word), VEC[v][7]);
            chk(TAG[v], "register after", from_word(regs[VEC[v][1] + 4]), VEC[v][8]);
            chk(TAG[v], "memory reads", n_mem, VEC[v][9]);
            chk(TAG[v], "code takes", n_take, VEC[v][7]);
            chk(TAG[v], "reg writes", n_we,
                (VEC[v][2] == 0 && VEC[v][0] >= 0 && VEC[v][0] <= 3) ? 1 : 0);
            chk(TAG[v], "latency", lat, (VEC[v][9] != 0) ? 4 : 2);
            @(negedge clk);
            chk("R11", "done after pulse", int'(done), 0);
        end

        // R11: start during a memory-mode fetch is ignored
        for (int r = 0; r < 9; r++) regs[r] = '0;
        regs[5] = to_word(10);
        @(negedge clk);
        mode_fld = to_word(-1); sel_fld = to_word(1); unary = 1'b0;
        n_done = 0; n_mem = 0;
        start = 1'b1;
        @(negedge clk);
        mode_fld = to_word(-4); sel_fld = to_word(4);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11", "done pulses", n_done, 1);
        chk("R11", "memory reads", n_mem, 1);
        chk("R11", "operand", from_word(operand), 51);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule